// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block works out the order in which a DDR2-style memory visits the columns of one burst. The controller gives it a starting column, a burst length of four or eight, and a burst kind, either sequential or interleaved. A one-cycle start pulse captures all three. The block then puts out one column address per clock with a valid flag, and raises a last flag on the final beat.

Only the three lowest column bits are reordered. The bits above them are copied through unchanged on every beat. In eight-beat sequential mode the count wraps inside each four-column half, and the second half is the first half with bit 2 inverted. In interleaved mode each beat is the start address XOR the beat index. The block handles no commands, banks, rows or data strobes. It only produces the access order.

Top module: `burst_colseq`

## Requirements
- R1: When the block is idle and start_i is high at a rising edge, col_i, bl8_i and ilv_i are captured at that edge, and from that edge on col_o shows the starting column as beat 0 with valid_o high.
- R2: For a four-beat burst (bl8_i=0) with sequential kind (ilv_i=0), beat i has col_o[1:0] = (start[1:0] + i) mod 4, and col_o[2] equals start bit 2.
- R3: For a four-beat burst (bl8_i=0) with interleaved kind (ilv_i=1), beat i has col_o[1:0] = start[1:0] XOR i, and col_o[2] equals start bit 2.
- R4: For an eight-beat burst (bl8_i=1) with interleaved kind (ilv_i=1), beat i has col_o[2:0] = start[2:0] XOR i.
- R5: For an eight-beat burst (bl8_i=1) with sequential kind (ilv_i=0), beat i has col_o[1:0] = (start[1:0] + i) mod 4, and col_o[2] equals start bit 2 for beats 0 to 3 and its inverse for beats 4 to 7.
- R6: col_o bits above bit 2 equal the captured col_i bits above bit 2 on every beat of the burst.
- R7: last_o is high only on beat 3 of a four-beat burst and only on beat 7 of an eight-beat burst, and only while valid_o is high.
- R8: valid_o goes low on the cycle after the last beat unless start_i is high at the edge that ends the last beat. In that case the next burst's beat 0 follows with no gap.
- R9: A start pulse during a burst, before its last beat, has no effect. Changes on col_i, bl8_i and ilv_i after the capturing edge do not alter the burst in progress.
- R10: A synchronous active-high rst clears valid_o and last_o and returns the block to idle, including in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst start pulse |
| col_i | input | COL_W | Starting column address |
| bl8_i | input | 1 | Burst length select: 0 for four beats, 1 for eight |
| ilv_i | input | 1 | Burst kind: 0 for sequential, 1 for interleaved |
| valid_o | output | 1 | A beat is being presented |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
Beat 0 is visible from the very edge that accepts the start pulse, and each later beat follows one edge after the one before it. The bench therefore drives inputs on falling edges and checks beat i at the i-th falling edge after the capturing falling edge. The drop of valid_o is checked one falling edge after the last beat. A reset is checked one falling edge after it is raised. The sweep covers every combination of start address, burst length and burst kind. During each burst the inputs are scrambled and a second start pulse is sent, so the ignore rules are seen at the ports. A chained start on a last beat and a reset in the middle of a burst complete the checks.

// File: rtl/burst_colseq_pkg.sv
package burst_colseq_pkg;
   // number of column bits that are reordered inside a burst
   localparam int unsigned ORDER_BITS = 3;
   localparam int unsigned MAX_BEATS  = 1 << ORDER_BITS;
   localparam int unsigned BEAT_W     = $clog2(MAX_BEATS);

   typedef enum logic {
      KIND_SEQ = 1'b0,
      KIND_ILV = 1'b1
   } burst_kind_e;

   typedef struct packed {
      logic        long_burst;
      burst_kind_e kind;
   } burst_cfg_t;
endpackage

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
   import burst_colseq_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              long_i,
   output logic              accept_o,
   output logic              valid_o,
   output logic              last_o,
   output logic [BEAT_W-1:0] beat_o
);
   localparam logic [BEAT_W-1:0] END_SHORT = BEAT_W'(MAX_BEATS / 2 - 1);
   localparam logic [BEAT_W-1:0] END_LONG  = BEAT_W'(MAX_BEATS - 1);

   logic              busy_q;
   logic [BEAT_W-1:0] cnt_q;
   logic [BEAT_W-1:0] end_beat;

   assign end_beat = long_i ? END_LONG : END_SHORT;
   assign last_o   = busy_q && (cnt_q == end_beat);
   assign accept_o = start_i && (!busy_q || last_o);
   assign valid_o  = busy_q;
   assign beat_o   = cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (accept_o) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (last_o) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      last_o |-> valid_o); // R7
   AST_BEAT_STEPS: assert property (@(posedge clk) disable iff (rst)
      (valid_o && !last_o) |=> (valid_o && beat_o == $past(beat_o) + 1'b1)); // R9
   AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      (last_o && !start_i) |=> !valid_o); // R8
   AST_CHAIN_RESTART: assert property (@(posedge clk) disable iff (rst)
      (last_o && start_i) |=> (valid_o && beat_o == '0)); // R8
endmodule

// File: rtl/bcs_order_map.sv
module bcs_order_map
   import burst_colseq_pkg::*;
(
   input  logic [ORDER_BITS-1:0] base_i,
   input  logic [BEAT_W-1:0]     beat_i,
   input  burst_cfg_t            cfg_i,
   output logic [ORDER_BITS-1:0] col_lo_o
);
   logic [1:0] quad_seq;
   logic [1:0] quad_ilv;
   logic       half_bit;

   // the two low bits rotate or flip inside a four-column group
   assign quad_seq = base_i[1:0] + beat_i[1:0];
   assign quad_ilv = base_i[1:0] ^ beat_i[1:0];
   // bit 2 moves only in the second half of a long burst, in both kinds
   assign half_bit = base_i[2] ^ (cfg_i.long_burst & beat_i[2]);

   always_comb begin
      col_lo_o[2]   = half_bit;
      col_lo_o[1:0] = (cfg_i.kind == KIND_ILV) ? quad_ilv : quad_seq;
   end

   always_comb begin
      if (beat_i == '0) begin
         AST_FIRST_IS_BASE: assert (col_lo_o == base_i); // R1
      end
   end
endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
   import burst_colseq_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [COL_W-1:0] col_i,
   input  logic             bl8_i,
   input  logic             ilv_i,
   output logic             valid_o,
   output logic [COL_W-1:0] col_o,
   output logic             last_o
);
   localparam int unsigned UP_W = COL_W - ORDER_BITS;

   if (COL_W < ORDER_BITS) begin : g_bad_width
      $error("burst_colseq: COL_W must be at least %0d", ORDER_BITS);
   end

   logic                  accept;
   logic [BEAT_W-1:0]     beat;
   logic [COL_W-1:0]      base_q;
   burst_cfg_t            cfg_q;
   logic [ORDER_BITS-1:0] col_lo;

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         cfg_q  <= '{long_burst: 1'b0, kind: KIND_SEQ};
      end else if (accept) begin
         base_q <= col_i;
         cfg_q  <= '{long_burst: bl8_i, kind: burst_kind_e'(ilv_i)};
      end
   end

   bcs_beat_ctr u_ctr (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start_i),
      .long_i   (cfg_q.long_burst),
      .accept_o (accept),
      .valid_o  (valid_o),
      .last_o   (last_o),
      .beat_o   (beat)
   );

   bcs_order_map u_map (
      .base_i   (base_q[ORDER_BITS-1:0]),
      .beat_i   (beat),
      .cfg_i    (cfg_q),
      .col_lo_o (col_lo)
   );

   if (UP_W > 0) begin : g_upper
      assign col_o = {base_q[COL_W-1:ORDER_BITS], col_lo};

      AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
         (valid_o && !last_o) |=> $stable(col_o[COL_W-1:ORDER_BITS])); // R6
   end else begin : g_no_upper
      assign col_o = col_lo;
   end

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (valid_o && !last_o && start_i) |=> (beat != '0)); // R9
endmodule

// File: tb/burst_colseq_bench.sv
`timescale 1ns/1ps
module burst_colseq_bench;
   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst;
   logic             start_i;
   logic [COL_W-1:0] col_i;
   logic             bl8_i;
   logic             ilv_i;
   logic             valid_o;
   logic [COL_W-1:0] col_o;
   logic             last_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   burst_colseq #(.COL_W(COL_W)) u_burst_colseq (
      .clk(clk), .rst(rst), .start_i(start_i), .col_i(col_i),
      .bl8_i(bl8_i), .ilv_i(ilv_i), .valid_o(valid_o),
      .col_o(col_o), .last_o(last_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_lo(input int s, input int i, input bit l8, input bit il);
      if (il) return l8 ? (s ^ i) : ((s & 4) | ((s ^ i) & 3));
      return ((s & 4) ^ ((l8 && i >= 4) ? 4 : 0)) | ((s + i) % 4);
   endfunction

   // at entry beat 0 is visible; returns at the falling edge of the last beat
   task automatic check_beats(input int up, input int s, input bit l8, input bit il);
      int n = l8 ? 8 : 4;
      string tag;
      tag = l8 ? (il ? "R4" : "R5") : (il ? "R3" : "R2");
      for (int i = 0; i < n; i++) begin
         chk(i == 0 ? "R1 valid" : "R8 valid", int'(valid_o), 1);
         chk(i == 0 ? "R1 column" : tag, int'(col_o[2:0]), exp_lo(s, i, l8, il));
         chk("R6 upper", int'(col_o[COL_W-1:3]), up);
         chk("R7 last", int'(last_o), (i == n - 1) ? 1 : 0);
         if (i < n - 1) begin
            // R9: stray start and scrambled inputs mid-burst
            start_i = (i == 1);
            col_i   = ~col_i;
            bl8_i   = ~bl8_i;
            ilv_i   = ~ilv_i;
            @(negedge clk);
         end
      end
   endtask

   initial begin
      rst = 1'b1; start_i = 1'b0; col_i = '0; bl8_i = 1'b0; ilv_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 reset valid", int'(valid_o), 0);
      chk("R10 reset last", int'(last_o), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R10 idle after reset", int'(valid_o), 0);

      // full sweep of length, kind and start address
      for (int l = 0; l < 2; l++) begin
         for (int k = 0; k < 2; k++) begin
            for (int s = 0; s < 8; s++) begin
               int up = (s * 37 + l * 5 + k * 11 + 3) & 127;
               col_i = COL_W'((up << 3) | s);
               bl8_i = l[0]; ilv_i = k[0]; start_i = 1'b1;
               @(negedge clk);
               start_i = 1'b0;
               check_beats(up, s, l[0], k[0]);
               start_i = 1'b0;
               @(negedge clk);
               chk("R8 idle after last", int'(valid_o), 0);
               chk("R8 last low", int'(last_o), 0);
            end
         end
      end

      // R8: chained start on the last beat of a short burst
      col_i = COL_W'((9 << 3) | 2); bl8_i = 1'b0; ilv_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check_beats(9, 2, 1'b0, 1'b0);
      col_i = COL_W'((77 << 3) | 5); bl8_i = 1'b1; ilv_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R8 chained no gap", int'(valid_o), 1);
      check_beats(77, 5, 1'b1, 1'b1);
      start_i = 1'b0;
      @(negedge clk);
      chk("R8 idle after chain", int'(valid_o), 0);

      // R10: reset in the middle of a long burst
      col_i = COL_W'((5 << 3) | 6); bl8_i = 1'b1; ilv_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R10 mid-burst reset valid", int'(valid_o), 0);
      chk("R10 mid-burst reset last", int'(last_o), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R10 stays idle", int'(valid_o), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule